// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block produces the bit-rate timing for a serial controller. A 16-bit down counter is loaded from a time constant (TC). When the count passes zero, one extra reload cycle follows and an output flip-flop toggles. That flip-flop yields a square baud clock with an even duty cycle. Each half period therefore lasts TC + 2 input clocks, and the output frequency is f_clk / (2·(TC + 2)). Software derives TC from TC = f_clk / (2 · rate · mode) − 2. For example, with a 9.8304 MHz clock and mode 1, TC = 0x007E gives 38400 and TC = 0x3FFE gives 300.

The time constant is written one byte at a time through a small write port. An enable input starts and stops the generator. A clock-mode divider counts rising edges of the baud clock and emits a one-cycle bit strobe every 1, 16, 32 or 64 of them. The transmitter and receiver use that strobe to pace their bits.

Top module: `baud_rate_gen`

## Requirements
- R1: Reset (rst_n low at a rising clk edge) drives baud_clk and bit_strobe to 0 and clears both time-constant bytes to 0, so that enabling without any write gives a half period of 2 clocks.
- R2: A write with wr_en high and wr_sel = 0 loads wr_data into TC bits 7:0; with wr_sel = 1 it loads TC bits 15:8; the other byte is unchanged.
- R3: While enable stays high and TC is unchanged, every half period of baud_clk (time between consecutive toggles) is exactly TC + 2 clocks.
- R4: The first toggle of baud_clk occurs TC + 2 clock edges after enable is set, counting from the first edge at which enable is sampled high, that edge included.
- R5: A TC write made while a half period is running does not change that half period; the new value applies from the next reload on.
- R6: While enable is low, baud_clk keeps its level and bit_strobe stays 0.
- R7: When enable rises again, a fresh half period of TC + 2 clocks starts, and baud_clk then toggles from the level it held.
- R8: mode_sel selects the divider: 00 gives 1, 01 gives 16, 10 gives 32, 11 gives 64. bit_strobe is high in exactly the cycles where baud_clk has just risen for the m-th, 2m-th, ... time counted from the latest enable start.
- R9: bit_strobe is never high for two consecutive cycles.
- R10: TC = 0 is legal and gives the fastest output, a half period of 2 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that the counter divides |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Time-constant byte write strobe |
| wr_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte value to write |
| enable | input | 1 | High to run the generator, low to freeze it |
| mode_sel | input | 2 | Clock-mode divider select (1/16/32/64) |
| baud_clk | output | 1 | Square-wave baud clock |
| bit_strobe | output | 1 | One-cycle strobe per bit time |

## Verification
Several counting mistakes are each caught by an exact interval. A design that skips the reload cycle would show TC + 1 instead of TC + 2. One that counts an extra cycle would show TC + 3. TC = 0 is tested because an off-by-one there would stall the output or make it toggle every clock.

A time constant rewritten in the middle of a half period tests whether the count in progress is disturbed; an eager reload would shorten that half period. The enable is dropped mid-count to confirm that the output level freezes. On restart, a full TC + 2 interval is expected, which catches a design that resumes the stale count.

Each divider mode is run over two strobe periods. This would expose a design that strobes on falling edges, strobes one edge early, or decodes the mode field in the wrong order.

// File: rtl/brg_pkg.sv
// Shared types and helpers for the baud rate generator.
// Assumes the mode field is two bits wide and encodes four divisors.
package brg_pkg;

    // Largest clock-mode divisor; sizes the mode divider counter.
    localparam int unsigned MAX_DIVISOR = 64;

    // Clock-mode selection codes as seen on the mode_sel port.
    typedef enum logic [1:0] {
        MODE_X1  = 2'b00,
        MODE_X16 = 2'b01,
        MODE_X32 = 2'b10,
        MODE_X64 = 2'b11
    } brg_mode_e;

    // Return the number of baud clock rising edges per bit strobe.
    function automatic int unsigned mode_divisor(brg_mode_e mode);
        case (mode)
            MODE_X1:  return 1;
            MODE_X16: return 16;
            MODE_X32: return 32;
            default:  return MAX_DIVISOR;
        endcase
    endfunction

endpackage

// File: rtl/brg_tc_regs.sv
// Time-constant register pair.
// Holds the reload value as BYTE_LANES separately written bytes.
// Assumes a write port of one byte lane per access, selected by sel.
// Writes change only the stored value; the counter reads it at reload.
module brg_tc_regs #(
    parameter int DATA_W     = 8,
    parameter int BYTE_LANES = 2,
    localparam int TC_W      = DATA_W * BYTE_LANES,
    localparam int SEL_W     = (BYTE_LANES > 1) ? $clog2(BYTE_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TC_W-1:0]   tc
);

    logic [BYTE_LANES-1:0][DATA_W-1:0] lane_q;

    // Store a written byte in the selected lane; clear every lane on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < BYTE_LANES; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    lane_q[i] <= wr_data;
                end
            end
        end
    end

    // Present the lanes as one little-endian reload word.
    assign tc = lane_q;

endmodule

// File: rtl/brg_half_counter.sv
// Reloading down counter with a divide-by-two output flip-flop.
// A half period is TC+2 clocks: TC down to 0 (TC+1 cycles) plus one
// reload cycle. The edge at which enable is first seen high loads TC
// and acts as the reload of the first half period.
// Assumes tc may change at any time; it is sampled only when loading.
module brg_half_counter #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [TC_W-1:0] tc,
    output logic            baud_clk,
    output logic            start,
    output logic            rise_tick
);

    logic            en_q;
    logic            reload_q;
    logic            baud_q;
    logic [TC_W-1:0] cnt_q;
    logic            running;
    logic            at_zero;
    logic            toggle;

    // Remember the previous enable so a rising edge can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= enable;
        end
    end

    assign start     = enable & ~en_q;
    assign running   = enable & en_q;
    assign at_zero   = (cnt_q == '0);
    assign toggle    = running & ~reload_q & at_zero;
    assign rise_tick = toggle & ~baud_q;

    // Count down, spend one reload cycle after zero, and hold when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= 1'b0;
        end else if (start) begin
            cnt_q    <= tc;
            reload_q <= 1'b0;
        end else if (running) begin
            if (reload_q) begin
                cnt_q    <= tc;
                reload_q <= 1'b0;
            end else if (at_zero) begin
                reload_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Divide-by-two stage: flip once per terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_q <= 1'b0;
        end else if (toggle) begin
            baud_q <= ~baud_q;
        end
    end

    assign baud_clk = baud_q;

endmodule

// File: rtl/brg_mode_div.sv
// Clock-mode divider: counts rising edges of the baud clock and raises
// a one-cycle strobe on every m-th one, m chosen by the mode field.
// The strobe is registered on the same edge at which the baud clock
// rises, so both become visible in the same cycle.
// Assumes rise_tick pulses are at least two cycles apart.
module brg_mode_div
    import brg_pkg::*;
#(
    parameter int DIV_W = $clog2(MAX_DIVISOR)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      rise_tick,
    input  brg_mode_e mode,
    output logic      strobe
);

    logic [DIV_W-1:0] edge_cnt_q;
    logic [DIV_W-1:0] last_edge;
    logic             wrap;

    assign last_edge = DIV_W'(mode_divisor(mode) - 1);
    assign wrap      = (edge_cnt_q >= last_edge);

    // Count baud rising edges, restarting from zero at each enable start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
        end else if (start) begin
            edge_cnt_q <= '0;
        end else if (rise_tick) begin
            edge_cnt_q <= wrap ? '0 : edge_cnt_q + 1'b1;
        end
    end

    // Raise the strobe for one cycle when the edge count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
        end else begin
            strobe <= rise_tick & wrap & ~start;
        end
    end

endmodule

// File: rtl/baud_rate_gen.sv
// Programmable baud rate generator top level.
// Byte-wise time-constant registers feed a reloading down counter with
// a divide-by-two output; an optional mode divider yields a bit strobe.
// Assumes a single clock domain and a synchronous active-low reset.
module baud_rate_gen
    import brg_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter bit STROBE_EN = 1'b1,
    localparam int LANES    = 2,
    localparam int TC_W     = DATA_W * LANES,
    localparam int DIV_W    = $clog2(MAX_DIVISOR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              enable,
    input  logic [1:0]        mode_sel,
    output logic              baud_clk,
    output logic              bit_strobe
);

    logic [TC_W-1:0] tc;
    logic            start;
    logic            rise_tick;

    brg_tc_regs #(
        .DATA_W     (DATA_W),
        .BYTE_LANES (LANES)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tc      (tc)
    );

    brg_half_counter #(
        .TC_W (TC_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tc        (tc),
        .baud_clk  (baud_clk),
        .start     (start),
        .rise_tick (rise_tick)
    );

    // Build the mode divider only when the strobe is wanted.
    generate
        if (STROBE_EN) begin : g_strobe
            brg_mode_div #(
                .DIV_W (DIV_W)
            ) u_div (
                .clk       (clk),
                .rst_n     (rst_n),
                .start     (start),
                .rise_tick (rise_tick),
                .mode      (brg_mode_e'(mode_sel)),
                .strobe    (bit_strobe)
            );
        end else begin : g_no_strobe
            logic unused_bits;
            assign unused_bits = ^{start, rise_tick, mode_sel};
            assign bit_strobe  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/brg_checker.sv
// Property checker for the baud rate generator, attached by bind.
// Observes only top-level ports.
module brg_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic baud_clk,
    input logic bit_strobe
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!baud_clk && !bit_strobe)); // R1
    AST_MIN_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) ($rose(baud_clk) || $fell(baud_clk)) |=> $stable(baud_clk)); // R10
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> $stable(baud_clk)); // R6
    AST_NO_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !bit_strobe); // R6
    AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) bit_strobe |-> (baud_clk && !$past(baud_clk))); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bit_strobe |=> !bit_strobe); // R9

endmodule

bind baud_rate_gen brg_checker u_brg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .baud_clk   (baud_clk),
    .bit_strobe (bit_strobe)
);

// File: tb/baud_rate_gen_bench.sv
// Directed bench for the baud rate generator; inputs change and outputs
// are sampled on falling clock edges.
module baud_rate_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       enable = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       baud_clk;
    logic       bit_strobe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_rate_gen u_baud_rate_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .enable     (enable),
        .mode_sel   (mode_sel),
        .baud_clk   (baud_clk),
        .bit_strobe (bit_strobe)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; enable = 1'b0; wr_en = 1'b0; mode_sel = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_byte(input bit sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_tc(input logic [15:0] tc);
        write_byte(1'b0, tc[7:0]);
        write_byte(1'b1, tc[15:8]);
    endtask

    // Count falling edges until baud_clk changes level.
    task automatic wait_toggle(output int n);
        logic prev;
        prev = baud_clk;
        n = 0;
        while (baud_clk == prev && n < WAIT_LIMIT) begin
            @(negedge clk);
            n++;
        end
    endtask

    // R1 / R10: reset values and cleared time constant.
    task automatic t_reset_state();
        int n;
        do_reset();
        check(baud_clk == 1'b0, "R1 baud_clk after reset", baud_clk, 0);
        check(bit_strobe == 1'b0, "R1 bit_strobe after reset", bit_strobe, 0);
        enable = 1'b1;
        wait_toggle(n);
        check(n == 2, "R1 cleared TC first half period", n, 2);
        for (int i = 0; i < 3; i++) begin
            wait_toggle(n);
            check(n == 2, "R10 TC=0 half period", n, 2);
        end
    endtask

    // R2 / R3 / R4: steady half periods for a given time constant.
    task automatic t_period(input logic [15:0] tc, input string req);
        int n;
        do_reset();
        write_tc(tc);
        enable = 1'b1;
        wait_toggle(n);
        check(n == int'(tc) + 2, "R4 first toggle", n, int'(tc) + 2);
        for (int i = 0; i < 3; i++) begin
            wait_toggle(n);
            check(n == int'(tc) + 2, req, n, int'(tc) + 2);
        end
    endtask

    // R2: one byte rewritten alone, other byte kept.
    task automatic t_single_byte();
        int n;
        do_reset();
        write_tc(16'h0105);
        write_byte(1'b0, 8'h02);
        enable = 1'b1;
        wait_toggle(n);
        check(n == 16'h0102 + 2, "R2 high byte kept after low write", n, 16'h0102 + 2);
    endtask

    // R5: TC rewritten mid half period.
    task automatic t_midwrite();
        int n;
        do_reset();
        write_tc(16'd20);
        enable = 1'b1;
        fork
            begin repeat (6) @(negedge clk); write_tc(16'd3); end
            wait_toggle(n);
        join
        check(n == 22, "R5 running half period unchanged", n, 22);
        for (int i = 0; i < 2; i++) begin
            wait_toggle(n);
            check(n == 5, "R5 new TC after reload", n, 5);
        end
    endtask

    // R6 / R7: freeze while disabled, fresh half period on restart.
    task automatic t_hold();
        int n;
        logic held;
        do_reset();
        write_tc(16'd10);
        enable = 1'b1;
        wait_toggle(n);
        check(n == 12, "R3 half period before hold", n, 12);
        repeat (4) @(negedge clk);
        enable = 1'b0;
        held = baud_clk;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (baud_clk != held || bit_strobe != 1'b0) begin
                check(1'b0, "R6 output frozen while disabled", baud_clk, held);
            end
        end
        check(baud_clk == held, "R6 level held", baud_clk, held);
        enable = 1'b1;
        wait_toggle(n);
        check(n == 12, "R7 fresh half period on restart", n, 12);
        check(baud_clk == ~held, "R7 toggles from held level", baud_clk, ~held);
    endtask

    // R8 / R9: strobe placement for one divider mode.
    task automatic t_mode(input logic [1:0] sel, input int m);
        int  k;
        int  strobes;
        int  guard;
        logic prev_b;
        logic prev_s;
        bit  rising;
        do_reset();
        write_tc(16'd0);
        mode_sel = sel;
        enable = 1'b1;
        k = 0; strobes = 0; guard = 0;
        prev_b = baud_clk; prev_s = 1'b0;
        while (k < 2 * m && guard < WAIT_LIMIT) begin
            @(negedge clk);
            guard++;
            rising = baud_clk && !prev_b;
            if (rising) k++;
            if (bit_strobe) strobes++;
            if (rising || bit_strobe) begin
                check(bit_strobe == (rising && (k % m == 0)), "R8 strobe placement", bit_strobe, int'(rising && (k % m == 0)));
            end
            if (prev_s && bit_strobe) begin
                check(1'b0, "R9 strobe longer than one cycle", 2, 1);
            end
            prev_b = baud_clk;
            prev_s = bit_strobe;
        end
        check(strobes == 2, "R8 strobes over two bit times", strobes, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_period(16'd5, "R3 TC=5 half period");
        t_period(16'h007E, "R3 TC=0x007E half period");
        t_period(16'h0103, "R2 R3 two-byte TC half period");
        t_single_byte();
        t_midwrite();
        t_hold();
        t_mode(2'b00, 1);
        t_mode(2'b01, 16);
        t_mode(2'b10, 32);
        t_mode(2'b11, 64);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule